// File: doc/BRIEF.md
# Crystal Digital Trim Compensator

This block turns a 32.768 kHz crystal clock into a corrected one-second tick. A two-stage divider chain (a prescaler and a sub-second counter) counts the crystal clock, and a third counter groups seconds into ten-second correction intervals. A signed 4-bit trim code sets the correction in 10 ppm steps, from -60 ppm to +60 ppm. Positive codes make the tick faster by skipping single prescaler counts. Negative codes make it slower by holding the prescaler for one extra count.

The number of counts to adjust in each interval comes from a fractional accumulator. Each ten-second boundary adds the magnitude times a step constant to the accumulator. Every prescaler cycle that finds a whole count waiting applies one adjustment and subtracts one whole count. With the default constants, one 10 ppm step is 3.2768 counts per interval, so the long-run rate is exact. The trim code is captured only at interval boundaries.

A calibration output is high for the first half of each corrected second. A frequency counter on this pin shows the trimmed rate directly.

Top module: `crystal_trim`

## Requirements
- R1: While reset is low, `tick_1hz` is 0 and `cal_1hz` is 1. The captured code after reset means no correction, so the first ten-second interval is uncorrected whatever `trim_code` holds.
- R2: With no correction, each second lasts exactly PRE_DIV*SUB_DIV clock cycles. `tick_1hz` pulses high for one cycle at the start of every second.
- R3: `trim_code` bit 3 is the sign (0 = faster, 1 = slower) and bits 2:0 are the magnitude. Magnitudes 1..6 are 1..6 steps; magnitudes 0 and 7 mean no correction. So codes 0, 7, 8 and 15 leave every second at its nominal length.
- R4: At each interval boundary, the fraction F is replaced by F + mag*STEP_NUM. The interval that follows is adjusted by floor of that sum divided by STEP_DEN counts, and the remainder is kept for the next boundary.
- R5: On a positive code, each adjustment shortens the interval by one clock cycle (one prescaler count is skipped). On a negative code, each adjustment lengthens it by one cycle (the prescaler holds for one cycle).
- R6: At most one adjustment happens in any prescaler cycle. The N adjustments of an interval fall in its first N prescaler cycles. Second j (0-based) of the interval therefore deviates by min(SUB_DIV, max(0, N - j*SUB_DIV)) cycles.
- R7: `trim_code` is sampled only on the clock edge that ends an interval. Changes at any other time have no effect until the next boundary.
- R8: When the sign of the newly captured code differs from that of the previous one, the fraction is cleared before the new step is added.
- R9: `cal_1hz` rises in the same cycle as each `tick_1hz` pulse. It falls exactly once per second, after SUB_DIV/2 prescaler cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_32k | input | 1 | Crystal clock, the counted time base |
| rst_n | input | 1 | Synchronous active-low reset |
| trim_code | input | 4 | Signed trim code: bit 3 sign, bits 2:0 magnitude |
| tick_1hz | output | 1 | One-cycle pulse at the start of each corrected second |
| cal_1hz | output | 1 | Corrected 1 Hz square wave for calibration |

## Verification
Three things meet on the single clock edge that closes an interval: the second rollover, the capture of the trim code, and the load of the fractional accumulator. In every interval the bench drives a new code in the very last cycle before that edge, so the capture must take the freshest value. Right after the edge it drives a random decoy code, which must change nothing. The bench predicts the length of every second and the total cycle count of every interval from a model of the accumulator. A code taken one cycle late, or a decoy that leaks through, shows up as a mismatch in the second lengths and in the interval sum.

// File: rtl/ct_trim_pkg.sv
// Package: shared types for the crystal trim compensator.
// Assumes a 4-bit signed-magnitude trim code with two zero magnitudes.
package ct_trim_pkg;

    typedef struct packed {
        logic       neg;   // 1 = slow the tick down (insert counts)
        logic [2:0] mag;   // effective magnitude, 0..6 steps
    } trim_t;

    // Map a raw code to sign and effective magnitude; 0 and 7 give none.
    function automatic trim_t decode_trim(input logic [3:0] code);
        trim_t t;
        t.neg = code[3];
        t.mag = (code[2:0] == 3'd7) ? 3'd0 : code[2:0];
        return t;
    endfunction

endpackage

// File: rtl/ct_trim_decode.sv
// Trim decoder: splits the raw trim code into sign and effective step count.
// Assumes nothing about timing; purely combinational.
module ct_trim_decode
    import ct_trim_pkg::*;
(
    input  logic [3:0] code_i,
    output trim_t      trim_o
);

    // Decode sign and clamp the unused magnitude to zero.
    always_comb begin
        trim_o = decode_trim(code_i);
    end

endmodule

// File: rtl/ct_corr_accum.sv
// Correction accumulator: holds the fractional count owed to the divider.
// On each interval boundary it captures the code sign and adds mag*STEP_NUM;
// each applied adjustment removes STEP_DEN. A sign change clears the fraction.
// Assumes all owed whole counts are applied before the next boundary.
module ct_corr_accum
    import ct_trim_pkg::*;
#(
    parameter int STEP_NUM = 32768,
    parameter int STEP_DEN = 10000,
    parameter int ACC_W    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  trim_t            trim_i,
    input  logic             adj_i,
    output logic             pend_o,
    output logic             neg_o,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_base;
    logic             neg_q;

    // Choose the starting fraction for a load: kept, or cleared on sign change.
    always_comb begin
        acc_base = (trim_i.neg != neg_q) ? '0 : acc_q;
    end

    // Load at the boundary, subtract one whole count per adjustment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            neg_q <= 1'b0;
        end else if (load_i) begin
            neg_q <= trim_i.neg;
            acc_q <= acc_base + ACC_W'(STEP_NUM) * ACC_W'(trim_i.mag);
        end else if (adj_i) begin
            acc_q <= acc_q - ACC_W'(STEP_DEN);
        end
    end

    assign pend_o = (acc_q >= ACC_W'(STEP_DEN));
    assign neg_o  = neg_q;
    assign acc_o  = acc_q;

endmodule

// File: rtl/ct_div_chain.sv
// Divider chain: prescaler, sub-second counter and interval counter.
// At prescaler count ADJ_PT a pending adjustment either jumps the prescaler
// by two (skip) or holds it one cycle (insert); at most one per prescaler
// cycle. Registers the second tick and the half-duty calibration wave.
// Assumes PRE_DIV >= 4 and SUB_DIV >= 2.
module ct_div_chain #(
    parameter int PRE_DIV    = 256,
    parameter int SUB_DIV    = 128,
    parameter int INTERVAL_S = 10,
    parameter int PRE_W      = $clog2(PRE_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_i,
    input  logic             neg_i,
    output logic             skip_o,
    output logic             ins_o,
    output logic             bnd_o,
    output logic [PRE_W-1:0] pre_o,
    output logic             tick_o,
    output logic             cal_o
);

    localparam int SUB_W  = $clog2(SUB_DIV);
    localparam int DEC_W  = $clog2(INTERVAL_S);
    localparam int HALF   = SUB_DIV / 2;
    localparam int ADJ_PT = 1;

    logic [PRE_W-1:0] pre_q, pre_n;
    logic [SUB_W-1:0] sub_q, sub_n;
    logic [DEC_W-1:0] dec_q, dec_n;
    logic             held_q;
    logic             tick_q, cal_q;
    logic             at_adj, pre_last, sub_last, sec_wrap, bnd;

    // Decode the counter positions and the adjustment strobes.
    always_comb begin
        at_adj   = (pre_q == PRE_W'(ADJ_PT));
        pre_last = (pre_q == PRE_W'(PRE_DIV - 1));
        sub_last = (sub_q == SUB_W'(SUB_DIV - 1));
        sec_wrap = pre_last && sub_last;
        bnd      = sec_wrap && (dec_q == DEC_W'(INTERVAL_S - 1));
        ins_o    = pend_i && neg_i && at_adj && !held_q;
        skip_o   = pend_i && !neg_i && at_adj;
    end

    // Next prescaler value: hold, jump by two, wrap or count.
    always_comb begin
        if (ins_o)         pre_n = pre_q;
        else if (skip_o)   pre_n = pre_q + PRE_W'(2);
        else if (pre_last) pre_n = '0;
        else               pre_n = pre_q + PRE_W'(1);
    end

    // Next sub-second and interval counts, advanced on the lower stage wrap.
    always_comb begin
        sub_n = sub_q;
        dec_n = dec_q;
        if (pre_last) sub_n = sub_last ? '0 : sub_q + SUB_W'(1);
        if (sec_wrap) dec_n = (dec_q == DEC_W'(INTERVAL_S - 1)) ? '0 : dec_q + DEC_W'(1);
    end

    // Chain registers and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            sub_q  <= '0;
            dec_q  <= '0;
            held_q <= 1'b0;
            tick_q <= 1'b0;
            cal_q  <= 1'b1;
        end else begin
            pre_q  <= pre_n;
            sub_q  <= sub_n;
            dec_q  <= dec_n;
            held_q <= ins_o;
            tick_q <= sec_wrap;
            cal_q  <= (sub_n < SUB_W'(HALF));
        end
    end

    assign bnd_o  = bnd;
    assign pre_o  = pre_q;
    assign tick_o = tick_q;
    assign cal_o  = cal_q;

endmodule

// File: rtl/crystal_trim.sv
// Top: crystal digital trim compensator. Decodes the trim code, keeps the
// fractional correction owed, and drives the divider chain that produces the
// corrected second tick and calibration wave. Code changes apply from the
// next ten-second boundary. Defaults give 10 ppm per step at 32.768 kHz.
module crystal_trim #(
    parameter int PRE_DIV    = 256,
    parameter int SUB_DIV    = 128,
    parameter int INTERVAL_S = 10,
    parameter int STEP_NUM   = 32768,
    parameter int STEP_DEN   = 10000
) (
    input  logic       clk_32k,
    input  logic       rst_n,
    input  logic [3:0] trim_code,
    output logic       tick_1hz,
    output logic       cal_1hz
);
    import ct_trim_pkg::*;

    localparam int ACC_W = $clog2(STEP_DEN + 7 * STEP_NUM + 1);
    localparam int PRE_W = $clog2(PRE_DIV);

    trim_t            trim_dec;
    logic             pend, neg_lat;
    logic             adj_skip, adj_ins, int_bnd;
    logic [ACC_W-1:0] acc_val;
    logic [PRE_W-1:0] pre_val;

    ct_trim_decode u_dec (
        .code_i (trim_code),
        .trim_o (trim_dec)
    );

    ct_corr_accum #(
        .STEP_NUM (STEP_NUM),
        .STEP_DEN (STEP_DEN),
        .ACC_W    (ACC_W)
    ) u_acc (
        .clk    (clk_32k),
        .rst_n  (rst_n),
        .load_i (int_bnd),
        .trim_i (trim_dec),
        .adj_i  (adj_skip | adj_ins),
        .pend_o (pend),
        .neg_o  (neg_lat),
        .acc_o  (acc_val)
    );

    ct_div_chain #(
        .PRE_DIV    (PRE_DIV),
        .SUB_DIV    (SUB_DIV),
        .INTERVAL_S (INTERVAL_S),
        .PRE_W      (PRE_W)
    ) u_div (
        .clk    (clk_32k),
        .rst_n  (rst_n),
        .pend_i (pend),
        .neg_i  (neg_lat),
        .skip_o (adj_skip),
        .ins_o  (adj_ins),
        .bnd_o  (int_bnd),
        .pre_o  (pre_val),
        .tick_o (tick_1hz),
        .cal_o  (cal_1hz)
    );

endmodule

// File: rtl/ct_trim_chk.sv
// Checker: temporal properties of the trim compensator, bound to the top.
module ct_trim_chk #(
    parameter int PRE_W    = 8,
    parameter int ACC_W    = 18,
    parameter int STEP_DEN = 10000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cal,
    input logic             skip,
    input logic             ins,
    input logic             bnd,
    input logic             neg_lat,
    input logic [PRE_W-1:0] pre,
    input logic [ACC_W-1:0] acc
);

    p_tick_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_skip_jumps_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> (pre == $past(pre) + PRE_W'(2)));

    p_insert_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ins |=> (pre == $past(pre)));

    p_no_double_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins |=> !ins);

    p_whole_counts_spent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bnd |-> (acc < ACC_W'(STEP_DEN)));

    p_sign_held_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(neg_lat));

    p_cal_rises_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal) |-> tick);

    p_tick_brings_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> cal);

endmodule

bind crystal_trim ct_trim_chk #(
    .PRE_W    (PRE_W),
    .ACC_W    (ACC_W),
    .STEP_DEN (STEP_DEN)
) u_chk (
    .clk     (clk_32k),
    .rst_n   (rst_n),
    .tick    (tick_1hz),
    .cal     (cal_1hz),
    .skip    (adj_skip),
    .ins     (adj_ins),
    .bnd     (int_bnd),
    .neg_lat (neg_lat),
    .pre     (pre_val),
    .acc     (acc_val)
);

// File: tb/crystal_trim_tb.sv
// Bench: predicts every second length and interval length from a model of
// the fractional accumulator; directed codes first, then seeded random ones.
module crystal_trim_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_DIV    = 8;
    localparam int SUB_DIV    = 4;
    localparam int INTERVAL_S = 10;
    localparam int STEP_NUM   = 33;
    localparam int STEP_DEN   = 10;
    localparam int BASE       = PRE_DIV * SUB_DIV;
    localparam int N_INT      = 40;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] trim_r = 4'd6;
    logic       tick, cal;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crystal_trim #(
        .PRE_DIV    (PRE_DIV),
        .SUB_DIV    (SUB_DIV),
        .INTERVAL_S (INTERVAL_S),
        .STEP_NUM   (STEP_NUM),
        .STEP_DEN   (STEP_DEN)
    ) u_dut (
        .clk_32k   (clk),
        .rst_n     (rst_n),
        .trim_code (trim_r),
        .tick_1hz  (tick),
        .cal_1hz   (cal)
    );

    int    checks = 0;
    int    fails  = 0;
    int    acc_m  = 0;
    int    n_cur  = 0;
    bit    sign_m = 1'b0;
    string tag_cur = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected length of second j of the current interval (R6).
    function automatic int exp_len(input int j);
        int dev = n_cur - j * SUB_DIV;
        if (dev < 0) dev = 0;
        if (dev > SUB_DIV) dev = SUB_DIV;
        return sign_m ? BASE + dev : BASE - dev;
    endfunction

    // Boundary model: sign, magnitude, fraction (R3, R4, R8).
    task automatic model_load(input logic [3:0] c);
        int m = int'(c[2:0]);
        if (m == 7) m = 0;
        if (c[3] != sign_m) acc_m = 0;
        acc_m  = acc_m + m * STEP_NUM;
        n_cur  = acc_m / STEP_DEN;
        acc_m  = acc_m % STEP_DEN;
        sign_m = c[3];
    endtask

    function automatic logic [3:0] plan_code(input int k);
        case (k)
            1: return 4'd0;
            2: return 4'd7;
            3: return 4'd8;
            4: return 4'd15;
            5: return 4'd6;
            6: return 4'd6;
            7: return 4'd14;
            8: return 4'd1;
            9: return 4'd9;
            10: return 4'd3;
            default: return 4'($urandom_range(0, 15));
        endcase
    endfunction

    function automatic string int_tag(input int k, input logic [3:0] c);
        if (c[2:0] == 3'd0 || c[2:0] == 3'd7) return "R3";
        if (k == 7 || k == 10) return "R8";
        if (k <= 6) return "R4";
        return "R7";
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        summary();
        $finish;
    end

    initial begin
        int  sec = 0, since = 0, falls = 0, sum = 0, k_cur = 0, e = 0;
        bit  prev_cal = 1'b1;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R1", "tick during reset", int'(tick), 0);
        check(cal == 1'b1, "R1", "cal during reset", int'(cal), 1);
        rst_n = 1'b1;
        while (sec < N_INT * INTERVAL_S + 1) begin
            @(negedge clk);
            since++;
            if (prev_cal && !cal) falls++;
            if (tick) begin
                sec++;
                check(cal && !prev_cal, "R9", "cal rises with tick",
                      int'({prev_cal, cal}), 1);
                if (sec >= 2) begin
                    e = exp_len((sec - 1) % INTERVAL_S);
                    check(since == e, (k_cur == 0) ? "R1" : (n_cur > 0 ? "R6" : "R2"),
                          "second length", since, e);
                    check(falls == 1, "R9", "cal falls per second", falls, 1);
                    sum += since;
                end
                if (sec % INTERVAL_S == 0) begin
                    if (k_cur >= 1) begin
                        e = sign_m ? INTERVAL_S * BASE + n_cur : INTERVAL_S * BASE - n_cur;
                        check(sum == e, tag_cur, "interval length", sum, e);
                        if (n_cur > 0)
                            check(sign_m ? (sum > INTERVAL_S * BASE) : (sum < INTERVAL_S * BASE),
                                  "R5", "correction direction", sum, INTERVAL_S * BASE);
                    end
                    sum = 0;
                    k_cur++;
                    model_load(trim_r);
                    tag_cur = int_tag(k_cur, trim_r);
                    trim_r = 4'($urandom_range(0, 15));   // decoy, must be ignored (R7)
                end
                falls = 0;
                since = 0;
            end else if (sec % INTERVAL_S == INTERVAL_S - 1 &&
                         since == exp_len(INTERVAL_S - 1) - 1) begin
                trim_r = plan_code(k_cur + 1);            // last cycle before boundary
            end
            prev_cal = cal;
        end
        summary();
        $finish;
    end

endmodule